// File: doc/BRIEF.md
# PHY management register file

This block is the management side of a 10/100 Ethernet PHY. A station manager reaches it over a two-wire serial bus: a clock (MDC) driven by the manager, and a shared data line (MDIO) that the PHY drives only while it returns read data. Both wires are oversampled in the block's own clock domain. A frame decoder recognises read and write frames addressed to the strapped PHY address. Frames for any other address are ignored.

Behind the decoder sits a small register file with these registers:

- **Control**: loopback, forced speed, auto-negotiation enable, power-down, restart and duplex.
- **Status**: the PHY's fixed ability bits, plus live link-up and negotiation-complete inputs.
- **Two identifiers.**
- **Advertisement.**
- **Link-partner ability**: loaded from the negotiation engine.
- **Expansion.**

The control bits follow their own rules. Software reset clears itself and locks out further control writes for a fixed number of cycles. A strap pin can hold auto-negotiation off. The duplex bit is writable only while auto-negotiation is off. The restart request becomes a single-cycle pulse.

The datapath reads the control state from dedicated outputs. The strap pins set the power-on values of the speed, duplex and auto-negotiation bits. A separate isolate pin silences the management interface entirely.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, with all straps high, negotiated full duplex high and link/completion inputs low, the registers read as follows. All other register addresses read 0x0000.

  | Address | Register | Value |
  |---|---|---|
  | 0 | control | 0x3100 |
  | 1 | status | 0x7849 |
  | 2 | identifier 1 | 0x0000 |
  | 3 | identifier 2 | the `PHY_ID2` parameter |
  | 4 | advertisement | 0x01E1 |
  | 5 | link-partner ability | 0x0080 |
  | 6 | expansion | 0x0000 |
- R2: Frame format and read timing.
  - A frame is at least 32 ones, then start bits 0,1, then a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address and a 5-bit register address, all MSB first, then two turnaround bits.
  - On a read, the block leaves MDIO undriven in the first turnaround bit and drives 0 in the second.
  - It then drives the 16 data bits MSB first, each valid at the next MDC rising edge, and releases MDIO after the last data bit.
  - On a write, the 16 data bits after the turnaround are taken MSB first.
- R3: A frame whose PHY address differs from `phy_addr_i` neither drives MDIO nor changes any register.
- R4: Software reset (control bit 15).
  - Writing 1 to control bit 15 returns control, advertisement and link-partner registers to their reset values. The bit always reads 0.
  - For `RST_CYCLES` clock cycles afterwards, every write to the control register is ignored.
- R5: Control bit 14 (loopback) and control bit 11 (power-down) read back as written and drive `loopback_o` and `power_down_o`.
- R6: Control bit 13 (1 = 100 Mb/s) reads back its stored value and drives `speed_100_o`. Its reset value is `speed_strap_i`.
- R7: Control bit 12 (auto-negotiation enable).
  - It reads `an_strap_i` AND the stored bit. Its reset value is `an_strap_i`.
  - While `an_strap_i` is low, writes to it have no effect and `an_enable_o` stays 0.
- R8: Control bit 9 (restart).
  - Writing 1 to it produces a one-cycle pulse on `an_restart_o`, but only if auto-negotiation was enabled before that write.
  - The bit always reads 0.
- R9: Control bit 8 (duplex).
  - While auto-negotiation is enabled, it reads `neg_full_dup_i` and writes to it are ignored.
  - While auto-negotiation is disabled, it is read/write and drives `full_dup_o`. Its reset value is `duplex_strap_i`.
  - The enable state in effect before the write decides which case applies.
- R10: Control bit 10 and bits 7:0 read 0 whatever is written to them.
- R11: While `isolate_i` is high, MDIO is never driven and incoming frames change nothing.
- R12: Advertisement bits 10 and 8:5 are writable. The other advertisement bits keep their reset value. The status register ignores writes.
- R13: Status and link-partner inputs.
  - Status bit 2 follows `link_up_i` and bit 5 follows `an_done_i`.
  - A pulse on `lp_load_i` loads `lp_ability_i` into the link-partner register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples MDC |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Management data in |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| phy_addr_i | input | 5 | Strapped PHY address |
| isolate_i | input | 1 | Isolate strap, silences management |
| an_strap_i | input | 1 | Auto-negotiation allowed strap |
| speed_strap_i | input | 1 | Reset value of forced speed |
| duplex_strap_i | input | 1 | Reset value of forced duplex |
| neg_full_dup_i | input | 1 | Negotiated duplex result |
| link_up_i | input | 1 | Link status |
| an_done_i | input | 1 | Negotiation complete |
| lp_load_i | input | 1 | Load strobe for partner ability |
| lp_ability_i | input | 16 | Partner ability word |
| loopback_o | output | 1 | Loopback enable |
| power_down_o | output | 1 | Power-down request |
| an_enable_o | output | 1 | Effective auto-negotiation enable |
| an_restart_o | output | 1 | One-cycle restart pulse |
| speed_100_o | output | 1 | Forced speed (1 = 100 Mb/s) |
| full_dup_o | output | 1 | Forced duplex (1 = full) |

## Verification
The bench builds the block with `RST_CYCLES` = 2000 and `PHY_ID2` = 0xA5C3. MDC runs at 16 clocks per bit, so one 64-bit frame takes 1024 clocks. The 2000-cycle lockout therefore still covers a second write frame sent straight after the software reset, while a read frame that follows lands after the lockout has ended. With the default of 250 cycles, no frame could ever arrive inside the window. The distinctive identifier value shows that the parameter reaches the read path.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DW = 16;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_CTRL = 5'd0;
  localparam logic [AW-1:0] A_STAT = 5'd1;
  localparam logic [AW-1:0] A_ID1  = 5'd2;
  localparam logic [AW-1:0] A_ID2  = 5'd3;
  localparam logic [AW-1:0] A_ADV  = 5'd4;
  localparam logic [AW-1:0] A_LPA  = 5'd5;
  localparam logic [AW-1:0] A_EXP  = 5'd6;

  localparam logic [DW-1:0] STAT_BASE = 16'h7849;
  localparam logic [DW-1:0] ID1_VAL   = 16'h0000;
  localparam logic [DW-1:0] ADV_RST   = 16'h01E1;
  localparam logic [DW-1:0] ADV_WMASK = 16'h05E0;
  localparam logic [DW-1:0] LPA_RST   = 16'h0080;

  localparam int B_SRST  = 15;
  localparam int B_LOOP  = 14;
  localparam int B_SPD   = 13;
  localparam int B_ANEN  = 12;
  localparam int B_PDN   = 11;
  localparam int B_RSTRT = 9;
  localparam int B_DUP   = 8;
  localparam int B_LINK  = 2;
  localparam int B_ANOK  = 5;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef struct packed {
    logic loop;
    logic spd;
    logic an_en;
    logic pdn;
    logic dup;
  } ctrl_t;

  typedef enum logic [2:0] {S_PRE, S_ST, S_HDR, S_TA, S_DAT} mdio_st_e;
endpackage

// File: rtl/phy_mgmt_sync.sv
module phy_mgmt_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/phy_mdio_slave.sv
module phy_mdio_slave
  import phy_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mdc_s_i,
  input  logic          mdio_s_i,
  input  logic          isolate_i,
  input  logic [AW-1:0] phy_addr_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] PRE_MAX = CW'(PRE_LEN);

  mdio_st_e        st_q;
  logic            mdc_d_q;
  logic [CW-1:0]   ones_q;
  logic [4:0]      cnt_q;
  logic [10:0]     hdr_q;
  logic            is_rd_q;
  logic [DW-1:0]   sh_q;
  logic            out_q, oe_q, wr_q;
  logic            rise;
  logic [11:0]     hdr_n;

  assign rise  = mdc_s_i & ~mdc_d_q;
  assign hdr_n = {hdr_q, mdio_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_PRE;
      mdc_d_q <= 1'b0;
      ones_q  <= '0;
      cnt_q   <= '0;
      hdr_q   <= '0;
      is_rd_q <= 1'b0;
      sh_q    <= '0;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      mdc_d_q <= mdc_s_i;
      wr_q    <= 1'b0;
      if (isolate_i) begin
        st_q   <= S_PRE;
        ones_q <= '0;
        oe_q   <= 1'b0;
        out_q  <= 1'b1;
      end else if (rise) begin
        unique case (st_q)
          S_PRE: begin
            if (mdio_s_i) begin
              if (ones_q != PRE_MAX) ones_q <= ones_q + 1'b1;
            end else begin
              ones_q <= '0;
              if (ones_q == PRE_MAX) st_q <= S_ST;
            end
          end
          S_ST: begin
            cnt_q <= '0;
            st_q  <= mdio_s_i ? S_HDR : S_PRE;
          end
          S_HDR: begin
            hdr_q <= hdr_n[10:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 5'd11) begin
              cnt_q   <= '0;
              is_rd_q <= (hdr_n[11:10] == OP_RD);
              if (hdr_n[9:5] == phy_addr_i &&
                  (hdr_n[11:10] == OP_RD || hdr_n[11:10] == OP_WR))
                st_q <= S_TA;
              else
                st_q <= S_PRE;
            end
          end
          S_TA: begin
            if (cnt_q == 5'd0) begin
              cnt_q <= 5'd1;
              if (is_rd_q) begin
                oe_q  <= 1'b1;
                out_q <= 1'b0;
                sh_q  <= rd_data_i;
              end
            end else begin
              cnt_q <= '0;
              st_q  <= S_DAT;
              if (is_rd_q) begin
                out_q <= sh_q[DW-1];
                sh_q  <= {sh_q[DW-2:0], 1'b0};
              end
            end
          end
          S_DAT: begin
            cnt_q <= cnt_q + 1'b1;
            if (is_rd_q) begin
              if (cnt_q == 5'd15) begin
                oe_q  <= 1'b0;
                out_q <= 1'b1;
                st_q  <= S_PRE;
              end else begin
                out_q <= sh_q[DW-1];
                sh_q  <= {sh_q[DW-2:0], 1'b0};
              end
            end else begin
              sh_q <= {sh_q[DW-2:0], mdio_s_i};
              if (cnt_q == 5'd15) begin
                wr_q <= 1'b1;
                st_q <= S_PRE;
              end
            end
          end
          default: st_q <= S_PRE;
        endcase
      end
    end
  end

  assign mdio_o     = out_q;
  assign mdio_oe_o  = oe_q;
  assign reg_addr_o = hdr_q[4:0];
  assign wr_en_o    = wr_q;
  assign wr_data_o  = sh_q;

  // R2: first driven bit of a read is the turnaround zero
  a_r2_ta_drives_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);

  // R11: isolation silences the line on the next cycle
  a_r11_isolate_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isolate_i |=> !mdio_oe_o);
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] PHY_ID2    = 16'h5C41,
  parameter int          RST_CYCLES = 250
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          an_strap_i,
  input  logic          speed_strap_i,
  input  logic          duplex_strap_i,
  input  logic          neg_full_dup_i,
  input  logic          link_up_i,
  input  logic          an_done_i,
  input  logic          lp_load_i,
  input  logic [DW-1:0] lp_ability_i,
  output logic          loopback_o,
  output logic          power_down_o,
  output logic          an_enable_o,
  output logic          an_restart_o,
  output logic          speed_100_o,
  output logic          full_dup_o
);
  ctrl_t         ctrl_q, dflt;
  logic [DW-1:0] adv_q, lpa_q;
  logic          pend_q, restart_q;
  logic          an_eff, ctrl_wr, soft_rst, lock_busy;
  logic          unused_bits;

  assign dflt = '{loop: 1'b0, spd: speed_strap_i, an_en: an_strap_i,
                  pdn: 1'b0, dup: duplex_strap_i};
  assign an_eff   = an_strap_i & ctrl_q.an_en;
  assign ctrl_wr  = wr_en_i && addr_i == A_CTRL && !lock_busy && !pend_q;
  assign soft_rst = ctrl_wr && wr_data_i[B_SRST];
  assign unused_bits = ^{wr_data_i[10], wr_data_i[7:0]};

  generate
    if (RST_CYCLES > 0) begin : g_lock
      localparam int LW = $clog2(RST_CYCLES + 1);
      logic [LW-1:0] lock_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       lock_q <= '0;
        else if (soft_rst) lock_q <= LW'(RST_CYCLES);
        else if (lock_q != '0) lock_q <= lock_q - 1'b1;
      end
      assign lock_busy = (lock_q != '0);
    end else begin : g_nolock
      assign lock_busy = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '{loop: 1'b0, spd: 1'b1, an_en: 1'b1, pdn: 1'b0, dup: 1'b1};
      pend_q    <= 1'b1;
      adv_q     <= ADV_RST;
      lpa_q     <= LPA_RST;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (lp_load_i) lpa_q <= lp_ability_i;
      if (wr_en_i && addr_i == A_ADV)
        adv_q <= (wr_data_i & ADV_WMASK) | (ADV_RST & ~ADV_WMASK);
      if (pend_q) begin
        // straps are sampled once the reset is released
        ctrl_q <= dflt;
        pend_q <= 1'b0;
      end else if (soft_rst) begin
        ctrl_q <= dflt;
        adv_q  <= ADV_RST;
        lpa_q  <= LPA_RST;
      end else if (ctrl_wr) begin
        ctrl_q.loop <= wr_data_i[B_LOOP];
        ctrl_q.spd  <= wr_data_i[B_SPD];
        ctrl_q.pdn  <= wr_data_i[B_PDN];
        if (an_strap_i) ctrl_q.an_en <= wr_data_i[B_ANEN];
        if (!an_eff)    ctrl_q.dup   <= wr_data_i[B_DUP];
        restart_q <= wr_data_i[B_RSTRT] & an_eff;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rd_data_o[B_LOOP] = ctrl_q.loop;
        rd_data_o[B_SPD]  = ctrl_q.spd;
        rd_data_o[B_ANEN] = an_eff;
        rd_data_o[B_PDN]  = ctrl_q.pdn;
        rd_data_o[B_DUP]  = an_eff ? neg_full_dup_i : ctrl_q.dup;
      end
      A_STAT: begin
        rd_data_o = STAT_BASE;
        rd_data_o[B_LINK] = link_up_i;
        rd_data_o[B_ANOK] = an_done_i;
      end
      A_ID1:   rd_data_o = ID1_VAL;
      A_ID2:   rd_data_o = PHY_ID2;
      A_ADV:   rd_data_o = adv_q;
      A_LPA:   rd_data_o = lpa_q;
      A_EXP:   rd_data_o = '0;
      default: rd_data_o = '0;
    endcase
  end

  assign loopback_o   = ctrl_q.loop;
  assign power_down_o = ctrl_q.pdn;
  assign an_enable_o  = an_eff;
  assign an_restart_o = restart_q;
  assign speed_100_o  = ctrl_q.spd;
  assign full_dup_o   = ctrl_q.dup;

  // R4: control writes inside the lockout window leave control unchanged
  a_r4_lockout_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_busy && wr_en_i && addr_i == A_CTRL) |=> $stable(ctrl_q));

  // R4: software reset returns registers to their defaults
  a_r4_srst_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (adv_q == ADV_RST && lpa_q == LPA_RST && !ctrl_q.loop && !ctrl_q.pdn));

  // R8: restart pulse only follows an enabled negotiation
  a_r8_restart_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_restart_o |-> $past(an_eff));

  // R9: duplex is not writable while negotiation is enabled
  a_r9_dup_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && an_eff && !wr_data_i[B_SRST]) |=> $stable(ctrl_q.dup));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] PHY_ID2     = 16'h5C41,
  parameter int          RST_CYCLES  = 250,
  parameter int          PRE_LEN     = 32,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mdc_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic [4:0]  phy_addr_i,
  input  logic        isolate_i,
  input  logic        an_strap_i,
  input  logic        speed_strap_i,
  input  logic        duplex_strap_i,
  input  logic        neg_full_dup_i,
  input  logic        link_up_i,
  input  logic        an_done_i,
  input  logic        lp_load_i,
  input  logic [15:0] lp_ability_i,
  output logic        loopback_o,
  output logic        power_down_o,
  output logic        an_enable_o,
  output logic        an_restart_o,
  output logic        speed_100_o,
  output logic        full_dup_o
);
  logic [1:0]    pins_s;
  logic [AW-1:0] reg_addr;
  logic          wr_en;
  logic [DW-1:0] wr_data, rd_data;

  phy_mgmt_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mdc_i, mdio_i}),
    .q_o   (pins_s)
  );

  phy_mdio_slave #(.PRE_LEN(PRE_LEN)) u_slave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mdc_s_i   (pins_s[1]),
    .mdio_s_i  (pins_s[0]),
    .isolate_i (isolate_i),
    .phy_addr_i(phy_addr_i),
    .rd_data_i (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .reg_addr_o(reg_addr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data)
  );

  phy_mgmt_regfile #(.PHY_ID2(PHY_ID2), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en),
    .addr_i        (reg_addr),
    .wr_data_i     (wr_data),
    .rd_data_o     (rd_data),
    .an_strap_i    (an_strap_i),
    .speed_strap_i (speed_strap_i),
    .duplex_strap_i(duplex_strap_i),
    .neg_full_dup_i(neg_full_dup_i),
    .link_up_i     (link_up_i),
    .an_done_i     (an_done_i),
    .lp_load_i     (lp_load_i),
    .lp_ability_i  (lp_ability_i),
    .loopback_o    (loopback_o),
    .power_down_o  (power_down_o),
    .an_enable_o   (an_enable_o),
    .an_restart_o  (an_restart_o),
    .speed_100_o   (speed_100_o),
    .full_dup_o    (full_dup_o)
  );
endmodule

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;
  localparam int          HALF  = 8;
  localparam logic [4:0]  PA    = 5'h03;
  localparam logic [15:0] ID2   = 16'hA5C3;
  localparam int          LOCKC = 2000;
  localparam int          NV    = 19;

  // {write, reg, wdata, expected read}
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'd0,  16'h0000, 16'h3100},  // R1
    {1'b0, 5'd1,  16'h0000, 16'h7849},  // R1
    {1'b0, 5'd2,  16'h0000, 16'h0000},  // R1
    {1'b0, 5'd3,  16'h0000, 16'hA5C3},  // R1
    {1'b0, 5'd4,  16'h0000, 16'h01E1},  // R1
    {1'b0, 5'd5,  16'h0000, 16'h0080},  // R1
    {1'b0, 5'd6,  16'h0000, 16'h0000},  // R1
    {1'b0, 5'd7,  16'h0000, 16'h0000},  // R1 unimplemented
    {1'b0, 5'd31, 16'h0000, 16'h0000},  // R1 unimplemented
    {1'b1, 5'd4,  16'hFFFF, 16'h05E1},  // R12
    {1'b1, 5'd4,  16'h0000, 16'h0001},  // R12
    {1'b1, 5'd0,  16'h5000, 16'h5100},  // R5 R9
    {1'b1, 5'd0,  16'h0000, 16'h0100},  // R9 dup write ignored, AN was on
    {1'b1, 5'd0,  16'h2100, 16'h2100},  // R6 R9
    {1'b1, 5'd0,  16'h0000, 16'h0000},  // R6 R9
    {1'b1, 5'd0,  16'h04FF, 16'h0000},  // R10
    {1'b1, 5'd0,  16'h0200, 16'h0000},  // R8 reads 0
    {1'b1, 5'd1,  16'h0000, 16'h7849},  // R12 status read-only
    {1'b1, 5'd0,  16'h1800, 16'h1900}   // R5 R7
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mdc = 1'b0, mdio_in = 1'b1;
  logic mdio_o, mdio_oe_o;
  logic isolate = 1'b0, an_strap = 1'b1, spd_strap = 1'b1, dup_strap = 1'b1;
  logic neg_dup = 1'b1, link_up = 1'b0, an_done = 1'b0, lp_load = 1'b0;
  logic [15:0] lp_ab = 16'h0;
  logic loopback, pdown, an_en, an_rst, spd100, fdup;

  int n_chk = 0, n_err = 0, rs_cnt = 0;
  logic oe_seen = 1'b0;
  logic [15:0] rd;
  logic ok;

  always #2 clk = ~clk;

  phy_mgmt_regs #(.PHY_ID2(ID2), .RST_CYCLES(LOCKC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mdc_i(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .phy_addr_i(PA),
    .isolate_i(isolate), .an_strap_i(an_strap), .speed_strap_i(spd_strap),
    .duplex_strap_i(dup_strap), .neg_full_dup_i(neg_dup), .link_up_i(link_up),
    .an_done_i(an_done), .lp_load_i(lp_load), .lp_ability_i(lp_ab),
    .loopback_o(loopback), .power_down_o(pdown), .an_enable_o(an_en),
    .an_restart_o(an_rst), .speed_100_o(spd100), .full_dup_o(fdup)
  );

  always @(posedge clk) begin
    if (an_rst) rs_cnt <= rs_cnt + 1;
    if (mdio_oe_o) oe_seen <= 1'b1;
  end

  task automatic chk(input bit cond, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, output logic so, output logic soe);
    mdc = 1'b0;
    mdio_in = b;
    repeat (HALF) @(negedge clk);
    so  = mdio_o;
    soe = mdio_oe_o;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic rdop, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, output logic [15:0] rdv, output logic tok);
    logic so, soe;
    logic [13:0] hdr;
    hdr = {2'b01, rdop ? 2'b10 : 2'b01, pa, ra};
    tok = 1'b1;
    rdv = '0;
    for (int i = 0; i < 32; i++) bit_cycle(1'b1, so, soe);
    for (int i = 13; i >= 0; i--) bit_cycle(hdr[i], so, soe);
    bit_cycle(1'b1, so, soe);
    if (rdop && soe) tok = 1'b0;
    bit_cycle(rdop ? 1'b1 : 1'b0, so, soe);
    if (rdop && !(soe && !so)) tok = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      bit_cycle(rdop ? 1'b1 : wd[i], so, soe);
      rdv[i] = soe ? so : 1'b1;
      if (rdop && !soe) tok = 1'b0;
    end
    bit_cycle(1'b1, so, soe);
    if (soe) tok = 1'b0;
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] d;
    logic t;
    frame(1'b0, PA, ra, wd, d, t);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state at the ports
    chk(!loopback && !pdown && !mdio_oe_o && !an_rst, "R1 reset outputs", {12'h0, loopback, pdown, mdio_oe_o, an_rst}, 16'h0);
    chk(an_en && spd100 && fdup, "R1 R6 R7 strap defaults", {13'h0, an_en, spd100, fdup}, 16'h7);

    // R2 read framing and timing
    frame(1'b1, PA, 5'd0, 16'h0, rd, ok);
    chk(ok && rd == 16'h3100, "R2 read turnaround and data", rd, 16'h3100);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) wr(VEC[i][36:32], VEC[i][31:16]);
      frame(1'b1, PA, VEC[i][36:32], 16'h0, rd, ok);
      chk(ok && rd == VEC[i][15:0], $sformatf("R1/R5-R12 table entry %0d", i), rd, VEC[i][15:0]);
    end
    chk(pdown && an_en && !loopback, "R5 power-down output", {13'h0, pdown, an_en, loopback}, 16'h6);
    chk(rs_cnt == 0, "R8 no restart while AN off", 16'(rs_cnt), 16'h0);

    // R8 restart pulse while enabled
    wr(5'd0, 16'h1200);
    chk(rs_cnt == 1, "R8 restart pulse", 16'(rs_cnt), 16'h1);
    frame(1'b1, PA, 5'd0, 16'h0, rd, ok);
    chk(rd == 16'h1100, "R8 restart reads 0", rd, 16'h1100);

    // R9 negotiated duplex reflected, forced duplex protected
    neg_dup = 1'b0;
    frame(1'b1, PA, 5'd0, 16'h0, rd, ok);
    chk(rd == 16'h1000, "R9 reflects negotiated duplex", rd, 16'h1000);
    wr(5'd0, 16'h1100);
    chk(!fdup, "R9 duplex write ignored with AN on", {15'h0, fdup}, 16'h0);

    // R3 address filtering
    oe_seen = 1'b0;
    frame(1'b0, PA + 5'd1, 5'd0, 16'h5000, rd, ok);
    frame(1'b1, PA + 5'd1, 5'd0, 16'h0, rd, ok);
    chk(!oe_seen && !loopback, "R3 foreign address ignored", {14'h0, oe_seen, loopback}, 16'h0);

    // R11 isolate
    isolate = 1'b1;
    oe_seen = 1'b0;
    frame(1'b1, PA, 5'd0, 16'h0, rd, ok);
    wr(5'd0, 16'h5000);
    chk(!oe_seen && !loopback, "R11 isolated frames ignored", {14'h0, oe_seen, loopback}, 16'h0);
    isolate = 1'b0;
    frame(1'b1, PA, 5'd0, 16'h0, rd, ok);
    chk(ok && rd == 16'h1000, "R11 state unchanged after isolate", rd, 16'h1000);

    // R13 live status and partner ability
    link_up = 1'b1;
    an_done = 1'b1;
    @(negedge clk);
    lp_ab = 16'h45E1;
    lp_load = 1'b1;
    @(negedge clk);
    lp_load = 1'b0;
    frame(1'b1, PA, 5'd1, 16'h0, rd, ok);
    chk(rd == 16'h786D, "R13 status live bits", rd, 16'h786D);
    frame(1'b1, PA, 5'd5, 16'h0, rd, ok);
    chk(rd == 16'h45E1, "R13 partner ability load", rd, 16'h45E1);

    // R4 software reset and lockout
    wr(5'd4, 16'h0000);
    wr(5'd0, 16'h9800);
    wr(5'd0, 16'h4000);
    chk(!loopback && !pdown, "R4 write inside lockout ignored", {14'h0, loopback, pdown}, 16'h0);
    frame(1'b1, PA, 5'd0, 16'h0, rd, ok);
    chk(rd == 16'h3000, "R4 control defaults, bit15 reads 0", rd, 16'h3000);
    frame(1'b1, PA, 5'd4, 16'h0, rd, ok);
    chk(rd == 16'h01E1, "R4 advertisement restored", rd, 16'h01E1);
    frame(1'b1, PA, 5'd5, 16'h0, rd, ok);
    chk(rd == 16'h0080, "R4 partner ability restored", rd, 16'h0080);
    wr(5'd0, 16'h5000);
    chk(loopback, "R4 R5 writes accepted after lockout", {15'h0, loopback}, 16'h1);

    // R7 strap holds negotiation off
    an_strap = 1'b0;
    spd_strap = 1'b0;
    wr(5'd0, 16'h8000);
    repeat (LOCKC + 100) @(negedge clk);
    frame(1'b1, PA, 5'd0, 16'h0, rd, ok);
    chk(rd == 16'h0100 && !an_en, "R7 R6 strap-low defaults", rd, 16'h0100);
    wr(5'd0, 16'h1200);
    chk(rs_cnt == 1 && !an_en, "R7 R8 enable write blocked, no restart", 16'(rs_cnt), 16'h1);
    frame(1'b1, PA, 5'd0, 16'h0, rd, ok);
    chk(rd == 16'h0000 && !spd100, "R7 R9 readback with strap low", rd, 16'h0000);

    summary();
  end
endmodule